// File: doc/BRIEF.md
# Write-Protect Guard with One-Time Lock

This block sits between the instruction decoder of a serial non-volatile memory and its array core. It decides whether a single-word write, a multi-word page write or a whole-array write may proceed. The boundary of the protected region is held in a dedicated boundary register that lives outside the array. Every address at or above the boundary is protected while the protect-enable pin is high.

A sticky one-time lock bit freezes the boundary register permanently. The lock can only be set. It clears only on the model's reset, which stands in for power-on. The decoder presents each modifying request with an operation code, a start address and a word count. One cycle later the guard answers with exactly one of a grant pulse or a deny pulse. Boundary loads and lock requests arrive as single-cycle strobes. The boundary and the lock state can be read at all times on output ports.

Top module: `wp_guard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bnd_value_o` equals 2^ADDR_W, which leaves nothing protected. `otp_locked_o`, `grant_o` and `deny_o` are all low.
- R2: A cycle with `req_valid_i` high produces exactly one of `grant_o` or `deny_o` in the next cycle. A cycle without a request produces neither.
- R3: A request made while `wr_en_i` is low is always denied.
- R4: A single write (op code 0) to address A is denied when `prot_en_i` is high and A >= `bnd_value_o`. Otherwise it is granted, provided `wr_en_i` is high. `req_cnt_i` plays no part in a single write.
- R5: A page write (op code 1) with count N covers addresses (A+k) mod 2^ADDR_W for k = 0..N-1. It is denied as a whole when `prot_en_i` is high and any one of those addresses is at or above the boundary. With `prot_en_i` low, the boundary plays no part.
- R6: A page write whose count is 0 or greater than PAGE_MAX is denied, whatever the state of `prot_en_i`.
- R7: A whole-array write (op code 2) is denied when `prot_en_i` is high and `bnd_value_o` < 2^ADDR_W. Op code 3 is always denied.
- R8: A `bnd_load_i` strobe copies `bnd_value_i` into the boundary register one cycle later. The copy happens only when `wr_en_i` and `prot_en_i` are both high and the lock is clear. In every other case the boundary register keeps its value.
- R9: An `otp_set_i` strobe with `wr_en_i` and `prot_en_i` both high sets `otp_locked_o` from the next cycle on. Without both enables the strobe has no effect. Once set, the lock stays set until `rst`. A load in the same cycle as the lock strobe still takes effect.
- R10: Once `otp_locked_o` is high, `bnd_value_o` never changes again until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (models power-on) |
| prot_en_i | input | 1 | Protect-enable pin level |
| wr_en_i | input | 1 | Write-enable pin level |
| req_valid_i | input | 1 | Modifying request present this cycle |
| req_op_i | input | 2 | 0 single write, 1 page write, 2 whole-array write, 3 reserved |
| req_addr_i | input | ADDR_W | Start address |
| req_cnt_i | input | $clog2(PAGE_MAX+1) | Page-write word count |
| bnd_load_i | input | 1 | Boundary load strobe |
| bnd_value_i | input | ADDR_W+1 | Boundary value to load |
| otp_set_i | input | 1 | Lock strobe |
| grant_o | output | 1 | Request granted (one cycle after request) |
| deny_o | output | 1 | Request denied (one cycle after request) |
| bnd_value_o | output | ADDR_W+1 | Current boundary register |
| otp_locked_o | output | 1 | Lock bit state |

## Verification
The bench builds the guard with ADDR_W = 4 and PAGE_MAX = 4, giving a 16-word array. This small size puts every start address, every count from 0 to 5 and every op code within reach for each boundary value from 0 to 17 and for 31. Both protect-enable levels are covered, so every page that wraps past the top address is exercised. Both sides of the boundary comparison are hit, and so are the out-of-range boundary codes. Refused loads, refused lock requests, a load that coincides with the lock, and the frozen boundary after locking are each checked at the ports. A final reset shows that the lock clears.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    typedef enum logic [1:0] {
        WP_OP_SINGLE = 2'd0,
        WP_OP_PAGE   = 2'd1,
        WP_OP_ALL    = 2'd2,
        WP_OP_RSVD   = 2'd3
    } wp_op_e;

    typedef struct packed {
        logic grant;
        logic deny;
    } wp_verdict_t;

    // Number of words an operation touches; 0 flags a malformed count.
    function automatic int unsigned wp_span(input wp_op_e op,
                                            input int unsigned cnt,
                                            input int unsigned page_max);
        int unsigned n;
        n = 0;
        case (op)
            WP_OP_SINGLE: n = 1;
            WP_OP_PAGE:   n = (cnt >= 1 && cnt <= page_max) ? cnt : 0;
            default:      n = 0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/wp_bound_reg.sv
module wp_bound_reg #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_en,
    input  logic              wr_en,
    input  logic              load,
    input  logic [ADDR_W:0]   load_val,
    input  logic              lock_req,
    output logic [ADDR_W:0]   bound,
    output logic              locked
);
    localparam int BND_W = ADDR_W + 1;
    localparam logic [BND_W-1:0] OPEN_BOUND = BND_W'(1) << ADDR_W;

    logic enables_ok;
    logic load_ok;
    logic lock_ok;

    assign enables_ok = wr_en && prot_en;
    assign load_ok    = load && enables_ok && !locked;
    assign lock_ok    = lock_req && enables_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            bound  <= OPEN_BOUND;
            locked <= 1'b0;
        end else begin
            if (load_ok) begin
                bound <= load_val;
            end
            if (lock_ok) begin
                locked <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wp_range_check.sv
module wp_range_check #(
    parameter int ADDR_W   = 6,
    parameter int PAGE_MAX = 4
) (
    input  logic [ADDR_W-1:0]           start_addr,
    input  logic [$clog2(PAGE_MAX+1)-1:0] span,
    input  logic [ADDR_W:0]             bound,
    output logic                        any_hit,
    output logic                        region_nonempty
);
    localparam int BND_W = ADDR_W + 1;
    localparam logic [BND_W-1:0] DEPTH_V = BND_W'(1) << ADDR_W;

    logic [PAGE_MAX-1:0] hit;

    for (genvar k = 0; k < PAGE_MAX; k++) begin : g_word
        logic [ADDR_W-1:0] word_addr;
        logic              in_span;
        assign word_addr = start_addr + ADDR_W'(k);
        assign in_span   = (32'(span) > k);
        assign hit[k]    = in_span && ({1'b0, word_addr} >= bound);
    end

    assign any_hit         = |hit;
    assign region_nonempty = (bound < DEPTH_V);
endmodule

// File: rtl/wp_verdict.sv
module wp_verdict
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int PAGE_MAX = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  wp_op_e                        op,
    input  logic [$clog2(PAGE_MAX+1)-1:0] span,
    input  logic                          wr_en,
    input  logic                          prot_en,
    input  logic                          any_hit,
    input  logic                          region_nonempty,
    output wp_verdict_t                   verdict
);
    logic permit;

    always_comb begin
        permit = 1'b0;
        if (wr_en) begin
            case (op)
                WP_OP_SINGLE,
                WP_OP_PAGE: permit = (span != '0) && !(prot_en && any_hit);
                WP_OP_ALL:  permit = !(prot_en && region_nonempty);
                default:    permit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else begin
            verdict.grant <= req_valid && permit;
            verdict.deny  <= req_valid && !permit;
        end
    end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int PAGE_MAX = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          prot_en_i,
    input  logic                          wr_en_i,
    input  logic                          req_valid_i,
    input  logic [1:0]                    req_op_i,
    input  logic [ADDR_W-1:0]             req_addr_i,
    input  logic [$clog2(PAGE_MAX+1)-1:0] req_cnt_i,
    input  logic                          bnd_load_i,
    input  logic [ADDR_W:0]               bnd_value_i,
    input  logic                          otp_set_i,
    output logic                          grant_o,
    output logic                          deny_o,
    output logic [ADDR_W:0]               bnd_value_o,
    output logic                          otp_locked_o
);
    localparam int CNT_W = $clog2(PAGE_MAX + 1);

    wp_op_e            op;
    logic [CNT_W-1:0]  span;
    logic              any_hit;
    logic              region_nonempty;
    wp_verdict_t       verdict;

    assign op   = wp_op_e'(req_op_i);
    assign span = CNT_W'(wp_span(op, 32'(req_cnt_i), PAGE_MAX));

    wp_bound_reg #(.ADDR_W(ADDR_W)) bound_i (
        .clk      (clk),
        .rst      (rst),
        .prot_en  (prot_en_i),
        .wr_en    (wr_en_i),
        .load     (bnd_load_i),
        .load_val (bnd_value_i),
        .lock_req (otp_set_i),
        .bound    (bnd_value_o),
        .locked   (otp_locked_o)
    );

    wp_range_check #(.ADDR_W(ADDR_W), .PAGE_MAX(PAGE_MAX)) range_i (
        .start_addr      (req_addr_i),
        .span            (span),
        .bound           (bnd_value_o),
        .any_hit         (any_hit),
        .region_nonempty (region_nonempty)
    );

    wp_verdict #(.ADDR_W(ADDR_W), .PAGE_MAX(PAGE_MAX)) verdict_i (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid_i),
        .op              (op),
        .span            (span),
        .wr_en           (wr_en_i),
        .prot_en         (prot_en_i),
        .any_hit         (any_hit),
        .region_nonempty (region_nonempty),
        .verdict         (verdict)
    );

    assign grant_o = verdict.grant;
    assign deny_o  = verdict.deny;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter int ADDR_W   = 6,
    parameter int PAGE_MAX = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          prot_en_i,
    input logic                          wr_en_i,
    input logic                          req_valid_i,
    input logic [1:0]                    req_op_i,
    input logic                          bnd_load_i,
    input logic                          grant_o,
    input logic                          deny_o,
    input logic [ADDR_W:0]               bnd_value_o,
    input logic                          otp_locked_o
);
    localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(1) << ADDR_W;

    a_r2_one_verdict: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> (grant_o ^ deny_o));

    a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!grant_o && !deny_o));

    a_r3_we_low_denies: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !wr_en_i) |=> deny_o);

    a_r7_all_denied: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_op_i == 2'd2 && prot_en_i && bnd_value_o < DEPTH_V) |=> deny_o);

    a_r8_load_gated: assert property (@(posedge clk) disable iff (rst)
        !(bnd_load_i && wr_en_i && prot_en_i) |=> $stable(bnd_value_o));

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        otp_locked_o |=> otp_locked_o);

    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        otp_locked_o |=> $stable(bnd_value_o));
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W), .PAGE_MAX(PAGE_MAX)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .prot_en_i    (prot_en_i),
    .wr_en_i      (wr_en_i),
    .req_valid_i  (req_valid_i),
    .req_op_i     (req_op_i),
    .bnd_load_i   (bnd_load_i),
    .grant_o      (grant_o),
    .deny_o       (deny_o),
    .bnd_value_o  (bnd_value_o),
    .otp_locked_o (otp_locked_o)
);

// File: tb/wp_guard_tb_top.sv
module wp_guard_tb_top;
    localparam int AW    = 4;
    localparam int PMAX  = 4;
    localparam int CW    = $clog2(PMAX + 1);
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prot_en_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [1:0]    req_op_i = '0;
    logic [AW-1:0] req_addr_i = '0;
    logic [CW-1:0] req_cnt_i = '0;
    logic          bnd_load_i = 1'b0;
    logic [AW:0]   bnd_value_i = '0;
    logic          otp_set_i = 1'b0;
    logic          grant_o, deny_o, otp_locked_o;
    logic [AW:0]   bnd_value_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wp_guard #(.ADDR_W(AW), .PAGE_MAX(PMAX)) dut_i (
        .clk(clk), .rst(rst), .prot_en_i(prot_en_i), .wr_en_i(wr_en_i),
        .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
        .req_cnt_i(req_cnt_i), .bnd_load_i(bnd_load_i), .bnd_value_i(bnd_value_i),
        .otp_set_i(otp_set_i), .grant_o(grant_o), .deny_o(deny_o),
        .bnd_value_o(bnd_value_o), .otp_locked_o(otp_locked_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_grant(int op, bit pe, bit we, int addr, int cnt, int bnd);
        int n;
        if (!we) return 1'b0;
        if (op == 3) return 1'b0;
        if (op == 2) return !(pe && bnd < DEPTH);
        if (op == 0) n = 1;
        else begin
            if (cnt < 1 || cnt > PMAX) return 1'b0;
            n = cnt;
        end
        for (int k = 0; k < n; k++) begin
            if (pe && ((addr + k) % DEPTH) >= bnd) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic string req_tag(int op, int cnt);
        if (op == 3) return "R7 reserved op";
        if (op == 2) return "R7 whole-array";
        if (op == 0) return "R4 single write";
        if (cnt < 1 || cnt > PMAX) return "R6 bad count";
        return "R5 page write";
    endfunction

    // One request; verdict registered at the following edge, sampled on the next negedge.
    task automatic do_req(int op, bit pe, bit we, int addr, int cnt);
        bit exp;
        exp = model_grant(op, pe, we, addr, cnt, int'(bnd_value_o));
        @(negedge clk);
        prot_en_i = pe; wr_en_i = we; req_valid_i = 1'b1;
        req_op_i = 2'(op); req_addr_i = AW'(addr); req_cnt_i = CW'(cnt);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(we ? req_tag(op, cnt) : "R3 write-enable low", int'(grant_o), int'(exp));
        chk("R2 exactly one verdict", int'(grant_o) + int'(deny_o), 1);
    endtask

    task automatic strobe(bit ld, bit lk, bit pe, bit we, int val);
        @(negedge clk);
        prot_en_i = pe; wr_en_i = we; bnd_load_i = ld; otp_set_i = lk;
        bnd_value_i = (AW+1)'(val);
        @(negedge clk);
        bnd_load_i = 1'b0; otp_set_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 bound in reset", int'(bnd_value_o), DEPTH);
        chk("R1 lock in reset", int'(otp_locked_o), 0);
        chk("R1 verdicts in reset", int'(grant_o) + int'(deny_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 bound after reset", int'(bnd_value_o), DEPTH);
        chk("R2 no request no verdict", int'(grant_o) + int'(deny_o), 0);

        // Refused loads
        strobe(1, 0, 1, 0, 5);
        chk("R8 load with write-enable low", int'(bnd_value_o), DEPTH);
        strobe(1, 0, 0, 1, 5);
        chk("R8 load with protect-enable low", int'(bnd_value_o), DEPTH);
        // Refused lock
        strobe(0, 1, 0, 1, 0);
        chk("R9 lock without protect-enable", int'(otp_locked_o), 0);
        strobe(0, 1, 1, 0, 0);
        chk("R9 lock without write-enable", int'(otp_locked_o), 0);

        // Full sweep for many boundaries
        for (int bi = 0; bi < 19; bi++) begin
            int b;
            b = (bi == 18) ? 31 : bi;
            strobe(1, 0, 1, 1, b);
            chk("R8 load accepted", int'(bnd_value_o), b);
            for (int op = 0; op < 4; op++)
                for (int a = 0; a < DEPTH; a++)
                    for (int c = 0; c < 6; c++)
                        for (int pe = 0; pe < 2; pe++)
                            do_req(op, pe[0], 1'b1, a, c);
            for (int op = 0; op < 4; op++)
                do_req(op, 1'b0, 1'b0, bi % DEPTH, 2);
        end

        // Load and lock in the same cycle
        strobe(1, 1, 1, 1, 9);
        chk("R9 lock set", int'(otp_locked_o), 1);
        chk("R9 same-cycle load applied", int'(bnd_value_o), 9);
        strobe(1, 0, 1, 1, 3);
        chk("R10 load after lock ignored", int'(bnd_value_o), 9);
        strobe(1, 1, 1, 1, 16);
        chk("R10 second lock and load ignored", int'(bnd_value_o), 9);
        chk("R9 lock stays set", int'(otp_locked_o), 1);
        for (int a = 0; a < DEPTH; a++) do_req(1, 1'b1, 1'b1, a, 3);
        do_req(2, 1'b1, 1'b1, 0, 1);

        // Reset clears the lock
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R9 lock cleared by reset", int'(otp_locked_o), 0);
        chk("R1 bound reopened by reset", int'(bnd_value_o), DEPTH);
        strobe(1, 0, 1, 1, 4);
        chk("R8 load after reset", int'(bnd_value_o), 4);

        done = 1'b1;
        finish_run();
    end
endmodule